// File: doc/BRIEF.md
# Instruction Single-Step Debug Controller

This block decides, cycle by cycle, whether a simple in-order processor may issue an instruction while hardware stepping is in use. It also decides when the step-complete exception is raised. Stepping is split into two phases. In the first phase the core runs exactly one instruction. In the second phase the step-complete exception is taken. The phase is kept in a processor-state step bit that this block owns. That bit is pushed onto a small saved-state stack when any exception is entered, and popped back on exception return. An interrupt that arrives while the stepped instruction runs is therefore serviced first, and the step exception follows on return without another instruction issuing.

The step state is decoded every cycle from the registered step bit together with two qualifiers: the debug-control step enable and a flag saying debug exceptions are allowed at the current privilege level and security state. The three states are off, armed and pending. The core reports retirement, interrupt presence, exception entry and exception return as strobes. A debug handler arms the next step by writing the top of the saved-state stack before it returns.

Top module: `step_debug_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the step bit and every saved-state entry to 0. With stepping disabled after reset, `issue_ok`=1, `step_exc`=0 and `ps_step_nxt`=0.
- R2: When `dbg_step_en`=0 or `dbg_exc_allow`=0 (off state), `issue_ok`=1 and `step_exc`=0, whatever the step bit and `irq` are.
- R3: When stepping is active and the step bit is 1 (armed), `issue_ok`=1 and `step_exc`=0, including in the cycle where `retire` is asserted.
- R4: A `retire` while armed clears the step bit. In the following cycle, with stepping still active and `irq`=0, `step_exc`=1 and `issue_ok`=0.
- R5: When stepping is active and the step bit is 0 (pending), `issue_ok`=0. `step_exc` is raised in the same cycle even if no step preceded, for example right after reset with stepping enabled.
- R6: While pending, `irq`=1 holds `step_exc` at 0 and `issue_ok` stays 0, so the interrupt is taken first.
- R7: `exc_enter` pushes the step bit onto the saved-state stack and clears the step bit. If `retire` clears the bit in the same armed cycle, the pushed value is 0. `exc_enter` takes priority over a same-cycle `exc_ret`.
- R8: `exc_ret` loads the step bit from the top of the saved-state stack. After an interrupt taken during the stepped instruction, the return restores 0 and `step_exc` is raised with no instruction issued.
- R9: `saved_wr` writes `saved_din` into the top saved-state entry, so a following `exc_ret` restores that value. The write is ignored in a cycle with `exc_enter` or `exc_ret`.
- R10: The saved-state stack holds `SAVE_DEPTH` entries and returns values last-in first-out. A pop shifts a 0 into the bottom entry. A push beyond the depth discards the oldest entry.
- R11: `retire` while stepping is off leaves the step bit unchanged.
- R12: `ps_step_nxt` equals the value the step bit takes at the next clock edge. It is 0 while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_step_en | input | 1 | Debug-control step enable |
| dbg_exc_allow | input | 1 | Debug exceptions allowed at current level and security state |
| retire | input | 1 | Instruction retire strobe |
| irq | input | 1 | Interrupt request pending |
| exc_enter | input | 1 | Exception entry strobe |
| exc_ret | input | 1 | Exception return strobe |
| saved_wr | input | 1 | Write strobe for the top saved-state step entry |
| saved_din | input | 1 | Value written by `saved_wr` |
| issue_ok | output | 1 | Instruction issue permitted |
| step_exc | output | 1 | Step-complete exception request |
| ps_step_nxt | output | 1 | Next value of the processor-state step bit |

## Verification
The decode is swept over every combination of step enable, allow flag and interrupt, with the step bit at both values. This separates the off, armed, pending and interrupt-masked outcomes. Directed sequences then drive a normal step (a retire while armed), an interrupt arriving together with the retire followed by a return, and a debugger re-arming the step through the saved entry. These show that retire alone raises nothing, that the pending phase survives an exception round trip, and that a rewritten saved entry changes the restored state. Nesting and overflow of the saved stack, the priority of entry over return, and a write ignored during entry each separate LIFO order, the zero fill on pop and strobe priority from a plain register.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

   typedef enum logic [1:0] {
      ST_OFF   = 2'd0,
      ST_ARMED = 2'd1,
      ST_PEND  = 2'd2
   } step_st_e;

   function automatic step_st_e step_decode(input logic active, input logic ps);
      if (!active)
         return ST_OFF;
      return ps ? ST_ARMED : ST_PEND;
   endfunction

endpackage

// File: rtl/sdc_decode.sv
module sdc_decode
   import sdc_pkg::*;
(
   input  logic step_en,
   input  logic exc_allow,
   input  logic ps_q,
   input  logic irq,
   output logic active,
   output logic issue_ok,
   output logic step_exc
);
   step_st_e st;

   always_comb begin
      active   = step_en & exc_allow;
      st       = step_decode(active, ps_q);
      issue_ok = 1'b1;
      step_exc = 1'b0;
      unique case (st)
         ST_OFF:   issue_ok = 1'b1;
         ST_ARMED: issue_ok = 1'b1;
         ST_PEND: begin
            issue_ok = 1'b0;
            step_exc = ~irq;
         end
         default: begin
            issue_ok = 1'b0;
            step_exc = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/sdc_save_stack.sv
module sdc_save_stack #(
   parameter int DEPTH = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic push,
   input  logic push_val,
   input  logic pop,
   input  logic wr,
   input  logic wr_val,
   output logic top
);
   generate
      if (DEPTH == 1) begin : g_single
         logic q;
         always_ff @(posedge clk) begin
            if (rst)       q <= 1'b0;
            else if (push) q <= push_val;
            else if (pop)  q <= 1'b0;
            else if (wr)   q <= wr_val;
         end
         assign top = q;
      end else begin : g_multi
         logic [DEPTH-1:0] stk;
         always_ff @(posedge clk) begin
            if (rst)       stk <= '0;
            else if (push) stk <= {stk[DEPTH-2:0], push_val};
            else if (pop)  stk <= {1'b0, stk[DEPTH-1:1]};
            else if (wr)   stk[0] <= wr_val;
         end
         assign top = stk[0];
      end
   endgenerate
endmodule

// File: rtl/sdc_psbit.sv
module sdc_psbit (
   input  logic clk,
   input  logic rst,
   input  logic active,
   input  logic retire,
   input  logic enter,
   input  logic ret,
   input  logic restore_val,
   output logic ps_q,
   output logic ps_d,
   output logic save_val
);
   logic stepped;

   always_comb begin
      stepped  = active & retire & ps_q;
      save_val = ps_q & ~stepped;
      if (rst)        ps_d = 1'b0;
      else if (enter) ps_d = 1'b0;
      else if (ret)   ps_d = restore_val;
      else            ps_d = save_val;
   end

   always_ff @(posedge clk) begin
      ps_q <= ps_d;
   end
endmodule

// File: rtl/step_debug_ctrl.sv
module step_debug_ctrl #(
   parameter int SAVE_DEPTH = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic dbg_step_en,
   input  logic dbg_exc_allow,
   input  logic retire,
   input  logic irq,
   input  logic exc_enter,
   input  logic exc_ret,
   input  logic saved_wr,
   input  logic saved_din,
   output logic issue_ok,
   output logic step_exc,
   output logic ps_step_nxt
);
   generate
      if (SAVE_DEPTH < 1) begin : g_bad_depth
         $error("step_debug_ctrl: SAVE_DEPTH must be at least 1");
      end
   endgenerate

   logic active;
   logic ps_q;
   logic save_val;
   logic top_val;

   sdc_decode u_dec (
      .step_en  (dbg_step_en),
      .exc_allow(dbg_exc_allow),
      .ps_q     (ps_q),
      .irq      (irq),
      .active   (active),
      .issue_ok (issue_ok),
      .step_exc (step_exc)
   );

   sdc_psbit u_ps (
      .clk        (clk),
      .rst        (rst),
      .active     (active),
      .retire     (retire),
      .enter      (exc_enter),
      .ret        (exc_ret),
      .restore_val(top_val),
      .ps_q       (ps_q),
      .ps_d       (ps_step_nxt),
      .save_val   (save_val)
   );

   sdc_save_stack #(.DEPTH(SAVE_DEPTH)) u_stk (
      .clk     (clk),
      .rst     (rst),
      .push    (exc_enter),
      .push_val(save_val),
      .pop     (exc_ret & ~exc_enter),
      .wr      (saved_wr),
      .wr_val  (saved_din),
      .top     (top_val)
   );
endmodule

// File: rtl/step_debug_ctrl_chk.sv
module step_debug_ctrl_chk (
   input logic clk,
   input logic rst,
   input logic dbg_step_en,
   input logic dbg_exc_allow,
   input logic retire,
   input logic irq,
   input logic exc_enter,
   input logic exc_ret,
   input logic issue_ok,
   input logic step_exc,
   input logic ps_step_nxt
);
   p_off_free_r2: assert property (@(posedge clk) disable iff (rst)
      !(dbg_step_en && dbg_exc_allow) |-> (issue_ok && !step_exc));

   p_retire_quiet_r3: assert property (@(posedge clk) disable iff (rst)
      (dbg_step_en && dbg_exc_allow && issue_ok && retire) |-> !step_exc);

   p_retire_pends_r4: assert property (@(posedge clk) disable iff (rst)
      (dbg_step_en && dbg_exc_allow && issue_ok && retire && !exc_enter && !exc_ret)
      |=> (!(dbg_step_en && dbg_exc_allow) || !issue_ok));

   p_irq_first_r6: assert property (@(posedge clk) disable iff (rst)
      irq |-> !step_exc);

   p_enter_clears_r7: assert property (@(posedge clk) disable iff (rst)
      exc_enter |=> (!(dbg_step_en && dbg_exc_allow) || !issue_ok));

   p_nxt_tracks_r12: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (!(dbg_step_en && dbg_exc_allow) || (issue_ok == $past(ps_step_nxt))));
endmodule

bind step_debug_ctrl step_debug_ctrl_chk u_chk (.*);

// File: tb/sim_step_debug_ctrl.sv
module sim_step_debug_ctrl;
   localparam int D = 4;

   logic clk = 1'b0;
   logic rst, dbg_step_en, dbg_exc_allow, retire, irq;
   logic exc_enter, exc_ret, saved_wr, saved_din;
   logic issue_ok, step_exc, ps_step_nxt;
   int   n_run = 0;
   int   n_fail = 0;

   always #2 clk = ~clk;

   step_debug_ctrl #(.SAVE_DEPTH(D)) u0 (.*);

   task automatic cyc;
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   task automatic set_ps(input logic v);
      saved_wr = 1'b1; saved_din = v;
      cyc();
      saved_wr = 1'b0; exc_ret = 1'b1;
      cyc();
      exc_ret = 1'b0;
   endtask

   task automatic do_reset;
      rst = 1'b1;
      cyc(); cyc();
      rst = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst = 1'b1; dbg_step_en = 0; dbg_exc_allow = 0; retire = 0; irq = 0;
      exc_enter = 0; exc_ret = 0; saved_wr = 0; saved_din = 0;
      #1;
      do_reset();
      #1;
      // R1 reset state
      chk("R1 issue_ok", issue_ok, 1'b1);
      chk("R1 step_exc", step_exc, 1'b0);
      chk("R1 ps_step_nxt", ps_step_nxt, 1'b0);
      // R5 pending without any prior step
      dbg_step_en = 1; dbg_exc_allow = 1; #1;
      chk("R5 step_exc after reset", step_exc, 1'b1);
      chk("R5 issue_ok after reset", issue_ok, 1'b0);
      dbg_step_en = 0; dbg_exc_allow = 0;
      cyc();

      // decode sweep: R2 R3 R5 R6 R12
      for (int p = 0; p < 2; p++) begin
         set_ps(p[0]);
         for (int c = 0; c < 8; c++) begin
            logic en, al, iq, act, e_iss, e_exc;
            string tg;
            en = c[2]; al = c[1]; iq = c[0];
            dbg_step_en = en; dbg_exc_allow = al; irq = iq;
            #1;
            act   = en & al;
            e_iss = !act | p[0];
            e_exc = act & !p[0] & !iq;
            if (!act)     tg = "R2";
            else if (p[0]) tg = "R3";
            else if (iq)  tg = "R6";
            else          tg = "R5";
            chk({tg, " issue_ok sweep"}, issue_ok, e_iss);
            chk({tg, " step_exc sweep"}, step_exc, e_exc);
            chk("R12 nxt holds", ps_step_nxt, p[0]);
            cyc();
         end
         dbg_step_en = 0; dbg_exc_allow = 0; irq = 0;
      end

      // R3/R4 normal step
      set_ps(1'b1);
      dbg_step_en = 1; dbg_exc_allow = 1; retire = 1; #1;
      chk("R3 no exc at retire", step_exc, 1'b0);
      chk("R3 issue at retire", issue_ok, 1'b1);
      chk("R12 nxt at retire", ps_step_nxt, 1'b0);
      cyc(); retire = 0; #1;
      chk("R4 step_exc after retire", step_exc, 1'b1);
      chk("R4 issue_ok after retire", issue_ok, 1'b0);

      // R11 retire while off
      dbg_step_en = 0; cyc();
      set_ps(1'b1);
      retire = 1; #1;
      chk("R11 nxt unchanged", ps_step_nxt, 1'b1);
      cyc(); retire = 0; dbg_step_en = 1; #1;
      chk("R11 still armed", issue_ok, 1'b1);
      chk("R11 no exc", step_exc, 1'b0);

      // R7/R8 interrupt during stepped instruction
      retire = 1; irq = 1; exc_enter = 1; #1;
      chk("R7 nxt cleared on enter", ps_step_nxt, 1'b0);
      cyc(); retire = 0; irq = 0; exc_enter = 0; dbg_exc_allow = 0; #1;
      chk("R2 handler free to issue", issue_ok, 1'b1);
      cyc();
      exc_ret = 1; #1;
      chk("R8 restore value 0", ps_step_nxt, 1'b0);
      cyc(); exc_ret = 0; dbg_exc_allow = 1; #1;
      chk("R8 step_exc after return", step_exc, 1'b1);
      chk("R8 no issue after return", issue_ok, 1'b0);

      // R9 debugger re-arms through saved entry
      exc_enter = 1; cyc(); exc_enter = 0;
      saved_wr = 1; saved_din = 1; cyc(); saved_wr = 0;
      exc_ret = 1; cyc(); exc_ret = 0; #1;
      chk("R9 re-armed issue_ok", issue_ok, 1'b1);
      chk("R9 re-armed step_exc", step_exc, 1'b0);

      // R7 enter without retire saves 1, enter beats return
      exc_enter = 1; exc_ret = 1; #1;
      chk("R7 enter over return", ps_step_nxt, 1'b0);
      cyc(); exc_enter = 0; exc_ret = 0;
      exc_ret = 1; #1;
      chk("R7 saved 1 restored", ps_step_nxt, 1'b1);
      cyc(); exc_ret = 0;

      // R10 LIFO order
      dbg_step_en = 0; dbg_exc_allow = 0;
      do_reset();
      set_ps(1'b1);
      exc_enter = 1; cyc(); cyc(); exc_enter = 0;
      exc_ret = 1; #1;
      chk("R10 first pop 0", ps_step_nxt, 1'b0);
      cyc(); #1;
      chk("R10 second pop 1", ps_step_nxt, 1'b1);
      cyc(); #1;
      chk("R10 zero fill", ps_step_nxt, 1'b0);
      cyc(); exc_ret = 0;

      // R9 write ignored during enter
      saved_wr = 1; saved_din = 1; exc_enter = 1;
      cyc(); saved_wr = 0; exc_enter = 0;
      exc_ret = 1; #1;
      chk("R9 write ignored on enter", ps_step_nxt, 1'b0);
      cyc(); exc_ret = 0;

      // R10 overflow drops oldest
      do_reset();
      set_ps(1'b1);
      exc_enter = 1;
      for (int k = 0; k < D + 1; k++) cyc();
      exc_enter = 0;
      exc_ret = 1;
      for (int k = 0; k < D; k++) begin
         #1;
         chk("R10 overflow pop", ps_step_nxt, (k + 1 > D) ? 1'b1 : 1'b0);
         cyc();
      end
      exc_ret = 0;

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule